// File: doc/BRIEF.md
# Field Memory Access Mode Controller

This block decides, field by field, whether an incoming decimated inset picture is written into a field memory, and it paces how the stored lines are read out. On the write side it watches a field start strobe together with a field identity bit. At each such boundary it chooses one of three actions for the coming field: write it, skip it, or hold the memory frozen. The choice depends on the display mode selection and on the freeze request. On the read side it turns display line strobes into address advance pulses. When line doubling is enabled, every stored line is shown twice before the read address moves on.

The mode selection has four values. In frame display every field is written. Two forced field modes keep only the first or only the second field. The fourth mode writes every other field and ignores the identity bit, which suits sources that only ever produce one kind of field. A freeze request is sampled only at a write-side field boundary, so a field that is partly written is always completed. While frozen, the memory keeps its content and the reader keeps displaying it. When freeze is released, writing starts again at the next field start that the selection rule accepts.

The write controller is a state machine with four states. WS_IDLE is the state after reset, before any field start has been seen. WS_WRITE means the current field is being stored. WS_SKIP means the current field is rejected by the selection rule. WS_FROZEN means writing is held off by freeze. On every field start, the machine moves from whatever state it is in to WS_FROZEN if freeze is requested. Otherwise it goes to WS_WRITE if the field passes the selection rule, and to WS_SKIP if it does not. Without a field start, the machine stays where it is. The read pacer has two states. RS_FIRST means the next line strobe shows a line for the first time. RS_SECOND means the next strobe is the repeat. A read field start forces RS_FIRST.

Top module: `fld_access_ctrl`

## Requirements
- R1: While reset is active and after it is released, wr_en is 0, rd_line_adv is 0 and frame_active is 1, until the first strobe.
- R2: With fld_sel = 2'b00 (frame mode) and no freeze, every field start sets wr_en to 1 from the next cycle until the next field start.
- R3: With fld_sel = 2'b01, only fields with wr_field_id = 0 are written. With fld_sel = 2'b10, only fields with wr_field_id = 1 are written. Rejected fields hold wr_en at 0.
- R4: With fld_sel = 2'b11, a toggle that resets to 0 flips on every write field start, whatever the mode. A field is written when the flipped value is 1, regardless of wr_field_id.
- R5: freeze_req is sampled only at a write field start. When it is set there, wr_en is 0 for that whole field. Raising it in the middle of a field leaves the current field's wr_en unchanged.
- R6: After freeze_req is cleared, writing resumes at the first field start whose field passes the rule of R2, R3 or R4.
- R7: With dbl_en = 0, every rd_line_strobe gives a one-cycle rd_line_adv pulse in the next cycle, and there is no pulse without a strobe.
- R8: With dbl_en = 1, strobes are paired and rd_line_adv pulses after the second strobe of each pair. An rd_field_start restarts the pairing, and a strobe in the same cycle counts as the first of a pair.
- R9: frame_active takes the value (fld_sel == 2'b00) at each write field start, visible one cycle later, and holds it otherwise.
- R10: wr_en changes only in the cycle after a write field start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_field_start | input | 1 | One-cycle strobe at the start of an incoming field |
| wr_field_id | input | 1 | Identity of the starting field: 0 first, 1 second |
| rd_field_start | input | 1 | One-cycle strobe at the start of a displayed field |
| rd_line_strobe | input | 1 | One-cycle strobe per displayed line |
| fld_sel | input | 2 | Display mode: 00 frame, 01 first only, 10 second only, 11 every other |
| dbl_en | input | 1 | Line doubling enable |
| freeze_req | input | 1 | Freeze request, sampled at write field starts |
| wr_en | output | 1 | Memory write enable for the current field |
| rd_line_adv | output | 1 | Read line address increment pulse |
| frame_active | output | 1 | Frame display active (1) or field display (0) |

## Verification
Every output goes through exactly one register. wr_en and frame_active therefore settle one cycle after the clock edge that samples wr_field_start, and rd_line_adv pulses one cycle after the edge that samples rd_line_strobe. The bench drives its inputs at falling edges. A behavioural model updates its expected values at each rising edge, and all three outputs are compared against it at the following falling edge on every cycle. As a result, a result that arrives a cycle early, a cycle late, or in the wrong field is reported in the cycle where it goes wrong.

// File: rtl/fld_access_pkg.sv
package fld_access_pkg;

    typedef enum logic [1:0] {
        SEL_FRAME  = 2'b00,
        SEL_FIRST  = 2'b01,
        SEL_SECOND = 2'b10,
        SEL_ALT    = 2'b11
    } fld_sel_e;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_WRITE,
        WS_SKIP,
        WS_FROZEN
    } wr_state_e;

    typedef enum logic {
        RS_FIRST,
        RS_SECOND
    } rd_state_e;

endpackage

// File: rtl/fld_wr_gate.sv
module fld_wr_gate
    import fld_access_pkg::*;
#(
    parameter logic FIRST_ID = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fld_start,
    input  logic     fld_id,
    input  fld_sel_e sel,
    input  logic     freeze,
    output logic     wr_en,
    output logic     frame_act
);

    localparam logic SECOND_ID = ~FIRST_ID;

    wr_state_e state_q, state_d, target;
    logic      tog_q, tog_nxt, pass;

    // selection rule for the field that is starting
    always_comb begin
        tog_nxt = ~tog_q;
        unique case (sel)
            SEL_FRAME:  pass = 1'b1;
            SEL_FIRST:  pass = (fld_id == FIRST_ID);
            SEL_SECOND: pass = (fld_id == SECOND_ID);
            SEL_ALT:    pass = tog_nxt;
            default:    pass = 1'b0;
        endcase
        if (freeze)
            target = WS_FROZEN;
        else if (pass)
            target = WS_WRITE;
        else
            target = WS_SKIP;
    end

    // next-state: every state leaves only on a field start
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:   if (fld_start) state_d = target;
            WS_WRITE:  if (fld_start) state_d = target;
            WS_SKIP:   if (fld_start) state_d = target;
            WS_FROZEN: if (fld_start) state_d = target;
            default:   state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= WS_IDLE;
            tog_q     <= 1'b0;
            frame_act <= 1'b1;
        end else begin
            state_q <= state_d;
            if (fld_start) begin
                tog_q     <= tog_nxt;
                frame_act <= (sel == SEL_FRAME);
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            WS_WRITE: wr_en = 1'b1;
            WS_IDLE,
            WS_SKIP,
            WS_FROZEN: wr_en = 1'b0;
            default:  wr_en = 1'b0;
        endcase
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fld_start |=> $stable(wr_en)); // R10
    AST_FREEZE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        fld_start && freeze |=> !wr_en); // R5
    AST_FRAME_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        fld_start && !freeze && sel == SEL_FRAME |=> wr_en && frame_act); // R2
    AST_FIRST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        fld_start && sel == SEL_FIRST && fld_id == SECOND_ID |=> !wr_en); // R3
    AST_SECOND_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        fld_start && sel == SEL_SECOND && fld_id == FIRST_ID |=> !wr_en); // R3
    AST_FIELD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fld_start && sel != SEL_FRAME |=> !frame_act); // R9

endmodule

// File: rtl/fld_rd_repeat.sv
module fld_rd_repeat
    import fld_access_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fld_start,
    input  logic line_stb,
    input  logic dbl,
    output logic adv
);

    rd_state_e state_q, state_d;
    logic      adv_d;

    always_comb begin
        state_d = state_q;
        adv_d   = 1'b0;
        if (fld_start) begin
            // strobe with a field start is the first showing of a line
            adv_d   = line_stb && !dbl;
            state_d = (line_stb && dbl) ? RS_SECOND : RS_FIRST;
        end else if (line_stb) begin
            unique case (state_q)
                RS_FIRST: begin
                    adv_d   = !dbl;
                    state_d = dbl ? RS_SECOND : RS_FIRST;
                end
                RS_SECOND: begin
                    adv_d   = 1'b1;
                    state_d = RS_FIRST;
                end
                default: begin
                    adv_d   = 1'b0;
                    state_d = RS_FIRST;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_FIRST;
            adv     <= 1'b0;
        end else begin
            state_q <= state_d;
            adv     <= adv_d;
        end
    end

    AST_ADV_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        line_stb && !dbl |=> adv); // R7
    AST_ADV_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stb |=> !adv); // R7
    AST_DBL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fld_start && dbl |=> !adv); // R8
    AST_DBL_NO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        dbl && $past(dbl) && line_stb && adv && !fld_start |=> !adv); // R8

endmodule

// File: rtl/fld_access_ctrl.sv
module fld_access_ctrl
    import fld_access_pkg::*;
#(
    parameter logic FIRST_ID = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_field_start,
    input  logic       wr_field_id,
    input  logic       rd_field_start,
    input  logic       rd_line_strobe,
    input  logic [1:0] fld_sel,
    input  logic       dbl_en,
    input  logic       freeze_req,
    output logic       wr_en,
    output logic       rd_line_adv,
    output logic       frame_active
);

    fld_sel_e sel_e;
    assign sel_e = fld_sel_e'(fld_sel);

    fld_wr_gate #(.FIRST_ID(FIRST_ID)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .fld_start (wr_field_start),
        .fld_id    (wr_field_id),
        .sel       (sel_e),
        .freeze    (freeze_req),
        .wr_en     (wr_en),
        .frame_act (frame_active)
    );

    fld_rd_repeat u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .fld_start (rd_field_start),
        .line_stb  (rd_line_strobe),
        .dbl       (dbl_en),
        .adv       (rd_line_adv)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !wr_en && !rd_line_adv); // R1

endmodule

// File: tb/fld_access_ctrl_test.sv
module fld_access_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_field_start = 1'b0, wr_field_id = 1'b0;
    logic rd_field_start = 1'b0, rd_line_strobe = 1'b0;
    logic [1:0] fld_sel = 2'b00;
    logic dbl_en = 1'b0, freeze_req = 1'b0;
    logic wr_en, rd_line_adv, frame_active;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural reference state
    bit m_wr = 0, m_adv = 0, m_frame = 1, m_tog = 0, m_pend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fld_access_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .wr_field_start(wr_field_start), .wr_field_id(wr_field_id),
        .rd_field_start(rd_field_start), .rd_line_strobe(rd_line_strobe),
        .fld_sel(fld_sel), .dbl_en(dbl_en), .freeze_req(freeze_req),
        .wr_en(wr_en), .rd_line_adv(rd_line_adv), .frame_active(frame_active)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wr = 0; m_adv = 0; m_frame = 1; m_tog = 0; m_pend = 0;
        end else begin
            if (wr_field_start) begin
                m_tog = !m_tog;
                m_frame = (fld_sel == 2'b00);
                if (freeze_req) m_wr = 0;
                else case (fld_sel)
                    2'b00: m_wr = 1;
                    2'b01: m_wr = (wr_field_id == 1'b0);
                    2'b10: m_wr = (wr_field_id == 1'b1);
                    default: m_wr = m_tog;
                endcase
            end
            if (rd_field_start) begin
                m_adv = rd_line_strobe && !dbl_en;
                m_pend = rd_line_strobe && dbl_en;
            end else if (rd_line_strobe) begin
                if (!dbl_en) begin m_adv = 1; m_pend = 0; end
                else if (m_pend) begin m_adv = 1; m_pend = 0; end
                else begin m_adv = 0; m_pend = 1; end
            end else begin
                m_adv = 0;
            end
        end
    end

    task automatic check_bit(string name, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_req, name, act, exp, $time);
        end
    endtask

    task automatic compare();
        check_bit("wr_en", wr_en, m_wr);
        check_bit("rd_line_adv", rd_line_adv, m_adv);
        check_bit("frame_active", frame_active, m_frame);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    // one write field with matching read field; dense puts a strobe on every cycle
    task automatic run_field(bit id, int lines, bit dense);
        wr_field_start = 1; wr_field_id = id;
        rd_field_start = 1; rd_line_strobe = dense;
        cyc();
        wr_field_start = 0; rd_field_start = 0;
        for (int k = 0; k < lines; k++) begin
            rd_line_strobe = dense ? 1'b1 : k[0];
            cyc();
        end
        rd_line_strobe = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1;
        @(negedge clk);
        compare();
        cyc();

        // R2 R7 R9: frame mode, no doubling
        cur_req = "R2";
        fld_sel = 2'b00;
        run_field(0, 6, 0);
        cur_req = "R7";
        run_field(1, 5, 1);
        run_field(0, 6, 0);

        // R3: forced first, then forced second; R9 frame_active drops
        cur_req = "R3";
        fld_sel = 2'b01;
        run_field(0, 4, 0);
        run_field(1, 4, 0);
        run_field(0, 4, 0);
        run_field(1, 4, 0);
        fld_sel = 2'b10;
        run_field(1, 4, 0);
        run_field(0, 4, 0);
        run_field(1, 4, 0);
        cur_req = "R9";
        fld_sel = 2'b00;
        run_field(1, 3, 0);

        // R4: every other field, field identity ignored
        cur_req = "R4";
        fld_sel = 2'b11;
        run_field(0, 4, 0);
        run_field(0, 4, 0);
        run_field(0, 4, 0);
        run_field(1, 4, 0);
        run_field(1, 4, 0);

        // R5: freeze raised mid-field, current field keeps writing
        cur_req = "R5";
        fld_sel = 2'b00;
        run_field(0, 2, 0);
        freeze_req = 1;
        repeat (4) cyc();
        run_field(1, 4, 0);
        run_field(0, 4, 0);
        // R6: release with forced first; id 1 skipped, id 0 written
        cur_req = "R6";
        fld_sel = 2'b01;
        freeze_req = 0;
        repeat (2) cyc();
        run_field(1, 4, 0);
        run_field(0, 4, 0);

        // R8: line doubling, odd line counts and dense strobes
        cur_req = "R8";
        fld_sel = 2'b00;
        dbl_en = 1;
        run_field(0, 7, 1);
        run_field(1, 8, 0);
        run_field(0, 5, 1);
        run_field(1, 6, 1);
        dbl_en = 0;

        // R10: no field start, toggle other inputs
        cur_req = "R10";
        fld_sel = 2'b01;
        wr_field_id = 1;
        freeze_req = 1;
        repeat (4) cyc();
        freeze_req = 0;
        fld_sel = 2'b10;
        repeat (4) cyc();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule